// File: doc/BRIEF.md
# Asynchronous SRAM cycle controller

This block sits between a synchronous host and an asynchronous static RAM that has a shared bidirectional data bus. The host asks for one read or one write at a time over a request/acknowledge handshake. The controller turns each request into a timed sequence on the memory pins: the address, active-low chip select, active-low write enable and active-low output enable. It also drives a data-out value with a separate driver-enable, so the shared bus can be built from an ordinary tristate pad outside the block.

Chip select frames each write. Write enable goes low first, together with the new address. Chip select then falls after the address-setup phase and rises after the write-pulse phase. The data driver stays on for a data-hold phase after the write ends. A recovery phase then keeps the address unchanged for the rest of the write-recovery interval. A read lowers chip select and output enable together with the new address. After the access phase it captures the bus. Every phase length is a parameter counted in clock cycles, each at least 1.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: Out of reset, and in every cycle outside a transfer, `sram_cs_n`, `sram_we_n` and `sram_oe_n` are 1, while `sram_dq_oe` and `host_ack` are 0.
- R2: Pin modes use active-low controls. During a read, `sram_cs_n`=0, `sram_we_n`=1 and `sram_oe_n`=0 for exactly T_ACC cycles, and `sram_dq_oe` stays 0. During a write, `sram_oe_n` stays 1 and `sram_cs_n` is 0 only while `sram_we_n` is 0.
- R3: In a write, `sram_we_n` falls with the new address exactly T_AS cycles before `sram_cs_n` falls.
- R4: The write window (`sram_cs_n` low) lasts exactly T_WP cycles. `sram_dq_oe` is 1 from the window's first cycle, and it turns on only inside the window.
- R5: After `sram_cs_n` rises, `sram_dq_oe` stays 1 for exactly T_DH cycles. `sram_dq_out` is stable for as long as the driver is enabled.
- R6: `sram_addr` holds the accepted address until the acknowledge. A write's `host_ack` is 1 in the cycle that begins T_AS+T_WP+max(T_WR,T_DH) clock edges after the accepting edge.
- R7: A read drives its new address from the edge after acceptance. It captures `sram_dq_in` into `host_rdata` T_ACC edges later, and `host_ack` is 1 in the cycle that follows that edge.
- R8: `sram_dq_oe` is never 1 while `sram_oe_n` is 0. `sram_oe_n` falls only after `sram_dq_oe` was 0 in the previous cycle.
- R9: `host_ack` is a one-cycle pulse. `host_rdata` changes only as `host_ack` rises and holds its value afterwards.
- R10: A request is accepted only in an idle cycle. Changing `host_we`, `host_addr` or `host_wdata` after the accepting edge has no effect on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_req | input | 1 | Transfer request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Transfer address |
| host_wdata | input | DW | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DW | Read data, valid with the acknowledge |
| sram_addr | output | AW | Memory address |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | DW | Data driven toward the shared bus |
| sram_dq_oe | output | 1 | Bus driver enable, active high |
| sram_dq_in | input | DW | Data sampled from the shared bus |

## Verification
The assertions assume the host keeps `host_req` high until it sees `host_ack`, and lowers it in the cycle after the pulse. They also assume reset is released away from a clock edge. The bench keeps to this: each request starts one idle cycle after the previous acknowledge, and the fields are scrambled only after acceptance. A bench-side memory model returns corrupted data until T_ACC cycles after an address change. It commits a write only on the rise of chip select, so the timing on the pins must be right for the expected data to come back.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSETUP = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WDHOLD = 3'd3,
    ST_WREC   = 3'd4,
    ST_RACC   = 3'd5,
    ST_DONE   = 3'd6
  } sram_state_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
    logic ack;
  } sram_pins_t;

  localparam sram_pins_t PINS_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                       dq_oe: 1'b0, ack: 1'b0};

  function automatic sram_pins_t decode_pins(sram_state_e st);
    sram_pins_t p;
    p = PINS_IDLE;
    case (st)
      ST_WSETUP: p.we_n = 1'b0;
      ST_WPULSE: begin
        p.we_n  = 1'b0;
        p.cs_n  = 1'b0;
        p.dq_oe = 1'b1;
      end
      ST_WDHOLD: p.dq_oe = 1'b1;
      ST_RACC: begin
        p.cs_n = 1'b0;
        p.oe_n = 1'b0;
      end
      ST_DONE:  p.ack = 1'b1;
      default:  p = PINS_IDLE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int T_AS  = 1,
  parameter int T_WP  = 2,
  parameter int T_WR  = 1,
  parameter int T_DH  = 1,
  parameter int T_ACC = 2,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic          tmr_zero,
  output sram_state_e   state_d,
  output logic          accept,
  output logic          rd_capture,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val
);

  // Recovery beyond the data-hold phase; zero removes the recovery state.
  localparam int  REC_EXTRA = (T_WR > T_DH) ? (T_WR - T_DH) : 0;
  localparam bit  HAS_REC   = (REC_EXTRA > 0);
  localparam int  REC_LEN   = HAS_REC ? REC_EXTRA : 1;

  localparam logic [CW-1:0] LD_AS  = CW'(T_AS - 1);
  localparam logic [CW-1:0] LD_WP  = CW'(T_WP - 1);
  localparam logic [CW-1:0] LD_DH  = CW'(T_DH - 1);
  localparam logic [CW-1:0] LD_REC = CW'(REC_LEN - 1);
  localparam logic [CW-1:0] LD_ACC = CW'(T_ACC - 1);

  sram_state_e state_q;

  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    accept     = 1'b0;
    rd_capture = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (req_we) begin
            state_d = ST_WSETUP;
            tmr_val = LD_AS;
          end else begin
            state_d = ST_RACC;
            tmr_val = LD_ACC;
          end
        end
      end
      ST_WSETUP: begin
        if (tmr_zero) begin
          state_d  = ST_WPULSE;
          tmr_load = 1'b1;
          tmr_val  = LD_WP;
        end
      end
      ST_WPULSE: begin
        if (tmr_zero) begin
          state_d  = ST_WDHOLD;
          tmr_load = 1'b1;
          tmr_val  = LD_DH;
        end
      end
      ST_WDHOLD: begin
        if (tmr_zero) begin
          if (HAS_REC) begin
            state_d  = ST_WREC;
            tmr_load = 1'b1;
            tmr_val  = LD_REC;
          end else begin
            state_d = ST_DONE;
          end
        end
      end
      ST_WREC: begin
        if (tmr_zero) begin
          state_d = ST_DONE;
        end
      end
      ST_RACC: begin
        if (tmr_zero) begin
          state_d    = ST_DONE;
          rd_capture = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sram_state_e   state_d,
  input  logic          accept,
  input  logic          rd_capture,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic [DW-1:0] bus_in,
  output sram_pins_t    pins_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);

  sram_pins_t pins_d;

  always_comb begin
    pins_d = decode_pins(state_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= PINS_IDLE;
    end else begin
      pins_q <= pins_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= host_addr;
      wdata_q <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_capture) begin
      rdata_q <= bus_in;
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int T_AS  = 1,
  parameter int T_WP  = 2,
  parameter int T_WR  = 1,
  parameter int T_DH  = 1,
  parameter int T_ACC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ack,
  output logic [DW-1:0] host_rdata,
  output logic [AW-1:0] sram_addr,
  output logic          sram_cs_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in
);

  localparam int MAX_AB = (T_AS > T_WP) ? T_AS : T_WP;
  localparam int MAX_CD = (T_WR > T_DH) ? T_WR : T_DH;
  localparam int MAX_ABCD = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int MAXT = (MAX_ABCD > T_ACC) ? MAX_ABCD : T_ACC;
  localparam int CW = (MAXT < 2) ? 1 : $clog2(MAXT);

  sram_state_e   state_d;
  logic          accept;
  logic          rd_capture;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;
  sram_pins_t    pins_q;

  sram_cycle_fsm #(
    .T_AS (T_AS),
    .T_WP (T_WP),
    .T_WR (T_WR),
    .T_DH (T_DH),
    .T_ACC(T_ACC),
    .CW   (CW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (host_req),
    .req_we    (host_we),
    .tmr_zero  (tmr_zero),
    .state_d   (state_d),
    .accept    (accept),
    .rd_capture(rd_capture),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val)
  );

  sram_phase_timer #(
    .CW(CW)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero    (tmr_zero)
  );

  sram_pin_regs #(
    .AW(AW),
    .DW(DW)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_d   (state_d),
    .accept    (accept),
    .rd_capture(rd_capture),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .bus_in    (sram_dq_in),
    .pins_q    (pins_q),
    .addr_q    (sram_addr),
    .wdata_q   (sram_dq_out),
    .rdata_q   (host_rdata)
  );

  assign sram_cs_n  = pins_q.cs_n;
  assign sram_we_n  = pins_q.we_n;
  assign sram_oe_n  = pins_q.oe_n;
  assign sram_dq_oe = pins_q.dq_oe;
  assign host_ack   = pins_q.ack;

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_ack,
  input logic [DW-1:0] host_rdata,
  input logic [AW-1:0] sram_addr,
  input logic          sram_cs_n,
  input logic          sram_we_n,
  input logic          sram_oe_n,
  input logic [DW-1:0] sram_dq_out,
  input logic          sram_dq_oe
);

  p_ack_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe));

  p_write_no_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);

  p_we_before_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sram_cs_n) && !sram_we_n) |-> $past(!sram_we_n));

  p_drv_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (!sram_cs_n && !sram_we_n));

  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out));

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sram_cs_n || !sram_we_n || sram_dq_oe) |-> $stable(sram_addr));

  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

  p_release_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_oe_n) |-> $past(!sram_dq_oe));

  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(host_rdata) |-> host_ack);

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
  .AW(AW),
  .DW(DW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_ack   (host_ack),
  .host_rdata (host_rdata),
  .sram_addr  (sram_addr),
  .sram_cs_n  (sram_cs_n),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_dq_out(sram_dq_out),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/tb_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module tb_sram_cycle_ctrl;

  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;
  localparam int T_AS  = 2;
  localparam int T_WP  = 3;
  localparam int T_WR  = 3;
  localparam int T_DH  = 1;
  localparam int T_ACC = 3;
  localparam int WR_LAT = T_AS + T_WP + ((T_WR > T_DH) ? T_WR : T_DH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_req;
  logic          host_we;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_wdata;
  logic          host_ack;
  logic [DW-1:0] host_rdata;
  logic [AW-1:0] sram_addr;
  logic          sram_cs_n;
  logic          sram_we_n;
  logic          sram_oe_n;
  logic [DW-1:0] sram_dq_out;
  logic          sram_dq_oe;
  logic [DW-1:0] sram_dq_in;

  always #2.5 clk = ~clk;

  sram_cycle_ctrl #(
    .AW(AW), .DW(DW), .T_AS(T_AS), .T_WP(T_WP),
    .T_WR(T_WR), .T_DH(T_DH), .T_ACC(T_ACC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_rdata(host_rdata), .sram_addr(sram_addr), .sram_cs_n(sram_cs_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] dev_mem [DEPTH];

  // Bus-side memory model
  int            addr_age = 0;
  logic [AW-1:0] last_addr = '0;
  logic          prev_cs_n = 1'b1;
  logic          prev_we_n = 1'b1;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_dq = '0;
  logic          prev_dq_oe = 1'b0;
  logic [DW-1:0] last_rdata = '0;

  assign sram_dq_in = (!sram_cs_n && sram_we_n && !sram_oe_n) ?
                      ((addr_age >= T_ACC - 1) ? dev_mem[sram_addr]
                                               : (dev_mem[sram_addr] ^ 16'hA5C3))
                      : '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (sram_addr != last_addr) addr_age = 0;
      else addr_age = addr_age + 1;
      last_addr = sram_addr;
      if (!prev_cs_n && !prev_we_n && sram_cs_n) begin
        chk(prev_dq_oe, "R4 driver on in window", prev_dq_oe, 1);
        dev_mem[prev_addr] = prev_dq;
      end
      if (sram_dq_oe && !sram_cs_n && sram_we_n && !sram_oe_n)
        chk(0, "R8 bus contention", 1, 0);
      prev_cs_n  = sram_cs_n;
      prev_we_n  = sram_we_n;
      prev_addr  = sram_addr;
      prev_dq    = sram_dq_out;
      prev_dq_oe = sram_dq_oe;
    end
  end

  task automatic check_idle(input string tag);
    chk(sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe && !host_ack,
        tag, {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, host_ack}, 5'b11100);
  endtask

  task automatic txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input int gap);
    int n = 0, setup = 0, pulse = 0, dh = 0, rd_cyc = 0;
    bit cs_seen = 0, addr_bad = 0, oe_bad = 0, we_bad = 0, rd_bad = 0;
    repeat (gap) begin
      @(negedge clk);
      check_idle("R1 idle between transfers");
    end
    @(negedge clk);
    check_idle("R9 ack single cycle / R1 idle");
    chk(host_rdata == last_rdata, "R9 rdata held", host_rdata, last_rdata);
    host_req   = 1'b1;
    host_we    = wr;
    host_addr  = a;
    host_wdata = d;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        // R10: scramble host fields after acceptance
        host_we    = !wr;
        host_addr  = ~a;
        host_wdata = ~d;
      end
      if (sram_addr != a) addr_bad = 1;
      if (wr) begin
        if (!sram_oe_n) oe_bad = 1;
        if (!sram_cs_n) begin
          pulse++;
          cs_seen = 1;
          if (sram_we_n) we_bad = 1;
        end else if (!cs_seen && !sram_we_n) begin
          setup++;
        end else if (cs_seen && sram_dq_oe) begin
          dh++;
        end
      end else begin
        if (sram_dq_oe || !sram_we_n) rd_bad = 1;
        if (!sram_cs_n && !sram_oe_n) rd_cyc++;
      end
    end while (!host_ack && n < 60);
    host_req = 1'b0;
    if (wr) begin
      chk(n == WR_LAT + 1, "R6 write ack latency", n, WR_LAT + 1);
      chk(setup == T_AS, "R3 address setup", setup, T_AS);
      chk(pulse == T_WP, "R4 write window", pulse, T_WP);
      chk(dh == T_DH, "R5 data hold", dh, T_DH);
      chk(!oe_bad && !we_bad, "R2 write mode", {oe_bad, we_bad}, 0);
      chk(!addr_bad, "R6 R10 address held", addr_bad, 0);
      ref_mem[a] = d;
    end else begin
      chk(n == T_ACC + 1, "R7 read ack latency", n, T_ACC + 1);
      chk(rd_cyc == T_ACC && !rd_bad, "R2 read mode", rd_cyc, T_ACC);
      chk(!addr_bad, "R7 R10 read address", addr_bad, 0);
      chk(host_rdata == ref_mem[a], "R7 R10 read data", host_rdata, ref_mem[a]);
    end
    last_rdata = host_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      ref_mem[i] = '0;
      dev_mem[i] = '0;
    end
    void'($urandom(32'd20240611));
    host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R1 pins during reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1 pins after reset");
    chk(host_rdata == '0, "R1 rdata after reset", host_rdata, 0);

    // Directed corners
    txn(1, '0, 16'h1234, 0);
    txn(0, '0, '0, 0);
    txn(1, AW'(DEPTH - 1), 16'hFFFF, 1);
    txn(0, AW'(DEPTH - 1), '0, 0);
    txn(0, AW'(17), '0, 2);
    txn(1, AW'(5), 16'h0001, 0);
    txn(1, AW'(5), 16'hBEEF, 0);
    txn(0, AW'(6), '0, 0);
    txn(0, AW'(5), '0, 0);

    // Constrained random mix
    for (int k = 0; k < 300; k++) begin
      logic [AW-1:0] a;
      a = ($urandom % 4 == 0) ? AW'($urandom % DEPTH) : AW'($urandom % 8);
      txn(bit'($urandom % 2), a, DW'($urandom), int'($urandom % 3));
    end
    for (int i = 0; i < 8; i++) txn(0, AW'(i), '0, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule